// File: doc/BRIEF.md
# Serial Configuration Bitstream Sequencer

This block is the read side of a serial configuration memory. It holds a one-bit-wide array and presents it, one location per rising edge of the configuration clock, to a device that is being configured. The device being configured owns all of the control: it supplies the configuration clock, an active-low chip enable and a combined reset/output-enable pin. No separate controller is needed to run the readout.

The data pin is modelled as a data bit `dout` plus a drive-enable `dout_en`, which stands in for a tri-state buffer. Address counting and output drive are gated together by reset/output-enable and chip enable. After the last stored bit has been shifted out, the block releases its data pin and pulls its cascade-enable output low. This lets the next memory in a chain take over a shared data line without contention. A synchronous write port, which is only accepted while the data pin is released, loads the array for test.

The array depth is the parameter `DEPTH`. Set it to 262144 for the full-size part; the default is smaller to keep elaboration light. While the data pin is released, `dout` reads 0.

Top module: `cfg_bitstream_seq`

## Requirements
- R1: While `por_n` is low, the address is held at 0, `dout_en` is low and `cascade_n` is high, with no reset/OE pulse needed. After `por_n` rises, with `ce_n` low and reset/OE at its enable level, `dout_en` is high and `dout` shows the bit at address 0.
- R2: Applying the reset level on `rst_oe` asynchronously clears the address to 0, drops `dout_en` and raises `cascade_n`, whatever the level of `ce_n`.
- R3: With `ce_n` high and reset/OE at its enable level, `dout_en` is low and rising clock edges do not move the address. When `ce_n` returns low, output resumes at the same bit.
- R4: With `ce_n` low, reset/OE at its enable level and the end not yet reached, `dout_en` is high and `dout` equals the stored bit at the current address.
- R5: The address holds its value across any rising edge at which the output is not being driven.
- R6: Each rising edge at which the output is driven, with the address below `DEPTH-1`, advances the address by exactly one.
- R7: The rising edge that is driven at address `DEPTH-1` ends the readout. From then on `cascade_n` is low, `dout_en` is low and the address saturates at `DEPTH-1`. This state lasts, across further clocks, until the next reset.
- R8: The polarity of `rst_oe` follows `RST_ACTIVE_HIGH`. When it is 1 (the default), high means reset and low means output enable. When it is 0, the meaning is inverted.
- R9: A write (`wr_en` high, with `wr_addr` and `wr_bit`) stores the bit at the rising edge only if `dout_en` is low at that edge. A write attempted while the output is driven leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock; all state changes on its rising edge |
| por_n | input | 1 | Power-on reset from supply monitor, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Combined reset / output enable, polarity set by `RST_ACTIVE_HIGH` |
| wr_en | input | 1 | Test write strobe |
| wr_addr | input | $clog2(DEPTH) | Test write address |
| wr_bit | input | 1 | Test write data |
| dout | output | 1 | Serial data bit (0 while released) |
| dout_en | output | 1 | Drive enable for the data pin |
| cascade_n | output | 1 | Cascade enable to the next device, low once readout is complete |

## Verification
Reset, chip enable and the terminal flag reach `dout_en` and `cascade_n` through logic only, so those results are due in the same cycle as the stimulus. The bench checks them 1 ns after changing the input, with no clock edge in between. An address advance, and so a new `dout` bit, appears after the rising edge that performs it. A write takes effect at the edge on which it is presented. The bench drives and samples 1 ns after each rising edge, and it keeps every reset pulse high across at least one edge, so that each expected value refers to a known edge count.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [1:0] {
    PH_HELD  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_DONE  = 2'd2
  } seq_phase_t;
endpackage

// File: rtl/cfg_pin_ctl.sv
module cfg_pin_ctl
  import cfg_seq_pkg::*;
#(
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic       por_n,
  input  logic       rst_oe,
  input  logic       ce_n,
  input  logic       done,
  output logic       clr,
  output logic       drive,
  output seq_phase_t phase
);
  logic rst_hit;

  generate
    if (RST_ACTIVE_HIGH) begin : g_pol_hi
      assign rst_hit = rst_oe;
    end else begin : g_pol_lo
      assign rst_hit = ~rst_oe;
    end
  endgenerate

  assign clr   = ~por_n | rst_hit;
  assign drive = ~clr & ~ce_n & ~done;

  always_comb begin
    if (done && !clr)  phase = PH_DONE;
    else if (drive)    phase = PH_SHIFT;
    else               phase = PH_HELD;
  end
endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
  parameter int DEPTH = 2048,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          cclk,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge cclk or posedge clr) begin
    if (clr) begin
      addr <= '0;
      done <= 1'b0;
    end else if (step) begin
      if (addr == LAST) done <= 1'b1;
      else              addr <= addr + 1'b1;
    end
  end

  // R5
  hold_when_idle_chk: assert property (@(posedge cclk) disable iff (clr)
    !step |=> $stable(addr));

  // R6
  advance_by_one_chk: assert property (@(posedge cclk) disable iff (clr)
    (step && addr != LAST) |=> (addr == $past(addr) + 1'b1));

  // R7
  terminal_saturate_chk: assert property (@(posedge cclk) disable iff (clr)
    (step && addr == LAST) |=> (done && addr == LAST));

  // R7
  done_sticky_chk: assert property (@(posedge cclk) disable iff (clr)
    done |=> (done && $stable(addr)));
endmodule

// File: rtl/cfg_bit_array.sv
module cfg_bit_array #(
  parameter int DEPTH = 2048,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          cclk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic          wd,
  input  logic [AW-1:0] ra,
  output logic          rd
);
  logic store [DEPTH];

  always_ff @(posedge cclk) begin
    if (we) store[wa] <= wd;
  end

  assign rd = store[ra];
endmodule

// File: rtl/cfg_bitstream_seq.sv
module cfg_bitstream_seq
  import cfg_seq_pkg::*;
#(
  parameter int DEPTH           = 2048,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  localparam int AW             = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          cclk,
  input  logic          por_n,
  input  logic          ce_n,
  input  logic          rst_oe,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  output logic          dout,
  output logic          dout_en,
  output logic          cascade_n
);
  logic          clr;
  logic          drive;
  logic          done;
  logic [AW-1:0] addr;
  logic          rd_bit;
  seq_phase_t    phase;

  cfg_pin_ctl #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_pin (
    .por_n (por_n),
    .rst_oe(rst_oe),
    .ce_n  (ce_n),
    .done  (done),
    .clr   (clr),
    .drive (drive),
    .phase (phase)
  );

  cfg_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .cclk(cclk),
    .clr (clr),
    .step(drive),
    .addr(addr),
    .done(done)
  );

  cfg_bit_array #(.DEPTH(DEPTH)) u_arr (
    .cclk(cclk),
    .we  (wr_en & ~drive),
    .wa  (wr_addr),
    .wd  (wr_bit),
    .ra  (addr),
    .rd  (rd_bit)
  );

  assign dout_en   = (phase == PH_SHIFT);
  assign dout      = rd_bit & dout_en;
  assign cascade_n = ~done;

  // R7
  cascade_release_chk: assert property (@(posedge cclk) disable iff (clr)
    !cascade_n |-> !dout_en);
endmodule

// File: tb/cfg_bitstream_seq_test.sv
module cfg_bitstream_seq_test;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          por_n, ce_n, rst_oe, wr_en, wr_bit;
  logic [AW-1:0] wr_addr;
  logic          dout, dout_en, cascade_n;

  logic       i_por_n, i_ce_n, i_rst, i_wr_en, i_wr_bit;
  logic [1:0] i_wr_addr;
  logic       i_dout, i_dout_en, i_cascade_n;

  int n_vec = 0;
  int n_bad = 0;
  int idx   = 0;
  logic ref_mem [DEPTH];

  cfg_bitstream_seq #(.DEPTH(DEPTH)) uut (
    .cclk(clk), .por_n(por_n), .ce_n(ce_n), .rst_oe(rst_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .dout(dout), .dout_en(dout_en), .cascade_n(cascade_n));

  cfg_bitstream_seq #(.DEPTH(4), .RST_ACTIVE_HIGH(1'b0)) uut_inv (
    .cclk(clk), .por_n(i_por_n), .ce_n(i_ce_n), .rst_oe(i_rst),
    .wr_en(i_wr_en), .wr_addr(i_wr_addr), .wr_bit(i_wr_bit),
    .dout(i_dout), .dout_en(i_dout_en), .cascade_n(i_cascade_n));

  function automatic logic pat(int i);
    return 1'(((i * 3) >> 1) ^ (i >> 3));
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_bit(string req);
    chk({req, " dout_en"}, dout_en, 1'b1);
    chk({req, " dout"}, dout, ref_mem[idx]);
  endtask

  task automatic reset_pulse();
    rst_oe = 1'b1;
    tick();
    rst_oe = 1'b0;
    #1;
    idx = 0;
  endtask

  // R1, R9: preload under power-on reset, then release
  task automatic t_power_up();
    chk("R1 dout_en in por", dout_en, 1'b0);
    chk("R1 cascade_n in por", cascade_n, 1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 1'b1; wr_addr = AW'(i); wr_bit = pat(i);
      ref_mem[i] = pat(i);
      tick();
    end
    wr_en = 1'b0;
    chk("R1 dout_en still low", dout_en, 1'b0);
    por_n = 1'b1;
    #1;
    idx = 0;
    check_bit("R1 first bit");
    chk("R1 cascade_n", cascade_n, 1'b1);
  endtask

  // R4, R6
  task automatic t_shift(int n);
    for (int k = 0; k < n; k++) begin
      tick();
      idx++;
      check_bit("R4 R6 shift");
    end
  endtask

  // R3, R5
  task automatic t_ce_hold();
    ce_n = 1'b1;
    #1;
    chk("R3 released on ce_n high", dout_en, 1'b0);
    for (int k = 0; k < 3; k++) tick();
    chk("R3 still released", dout_en, 1'b0);
    ce_n = 1'b0;
    #1;
    check_bit("R3 R5 resume same bit");
  endtask

  // R2: async reset, with ce_n both inactive and active
  task automatic t_reset_async();
    ce_n = 1'b1;
    rst_oe = 1'b1;
    #1;
    chk("R2 dout_en low", dout_en, 1'b0);
    chk("R2 cascade_n high", cascade_n, 1'b1);
    tick();
    ce_n = 1'b0;
    #1;
    chk("R2 held regardless of ce_n", dout_en, 1'b0);
    tick();
    rst_oe = 1'b0;
    #1;
    idx = 0;
    check_bit("R2 counter back at 0");
  endtask

  // R9: a write during readout must be ignored
  task automatic t_write_blocked();
    wr_en = 1'b1; wr_addr = AW'(20); wr_bit = ~ref_mem[20];
    tick();
    idx++;
    wr_en = 1'b0;
    check_bit("R9 readout continues");
    reset_pulse();
    t_shift(20);
    chk("R9 blocked write left bit", dout, ref_mem[20]);
  endtask

  // R7
  task automatic t_terminal();
    reset_pulse();
    check_bit("R7 start");
    t_shift(DEPTH - 1);
    chk("R7 cascade_n before end", cascade_n, 1'b1);
    tick();
    chk("R7 cascade_n low", cascade_n, 1'b0);
    chk("R7 dout_en released", dout_en, 1'b0);
    for (int k = 0; k < 3; k++) tick();
    chk("R7 cascade_n stays low", cascade_n, 1'b0);
    chk("R7 dout_en stays low", dout_en, 1'b0);
    rst_oe = 1'b1;
    #1;
    chk("R7 R2 cascade_n restored", cascade_n, 1'b1);
    tick();
    rst_oe = 1'b0;
    #1;
    idx = 0;
    check_bit("R7 restart at 0");
  endtask

  // R8: inverted polarity instance, low = reset
  task automatic t_polarity();
    i_rst = 1'b0;
    i_por_n = 1'b1;
    #1;
    chk("R8 low is reset", i_dout_en, 1'b0);
    tick();
    i_rst = 1'b1;
    #1;
    chk("R8 high enables", i_dout_en, 1'b1);
    for (int k = 0; k < 4; k++) tick();
    chk("R8 end after 4 bits", i_cascade_n, 1'b0);
    i_rst = 1'b0;
    #1;
    chk("R8 reset restores cascade_n", i_cascade_n, 1'b1);
    tick();
  endtask

  initial begin
    por_n = 1'b0; ce_n = 1'b0; rst_oe = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_bit = 1'b0;
    i_por_n = 1'b0; i_ce_n = 1'b0; i_rst = 1'b0;
    i_wr_en = 1'b0; i_wr_addr = '0; i_wr_bit = 1'b0;
    tick();
    t_power_up();
    t_shift(12);
    t_ce_hold();
    t_shift(3);
    t_reset_async();
    t_write_blocked();
    t_terminal();
    t_polarity();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule